// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns the synchronous "supply is below threshold" flag of an external voltage comparator into a clean system reset. It drives reset at power-on and holds it there. Reset asserts when a real undervoltage appears. Once the supply has been good for a fixed recovery time, reset is released. Very short dips below threshold are filtered out so that supply noise does not produce a reset pulse.

The comparator flag first passes through a two-flop synchronizer. A counter then measures how many consecutive clocks the flag has been set. A dip only counts as an undervoltage when that run reaches `GLITCH_CYCLES`, and any clock with the flag clear resets the count. When the undervoltage ends, a recovery timer of `TIMEOUT_CYCLES` clocks starts. Its default gives 240 ms at the nominal clock frequency. If another undervoltage qualifies while the timer is running, reset goes back to hold and the full timeout is served again. A static strap selects the output polarity, and the output is always driven to both levels.

Top module: `supply_reset_seq`

## Requirements
- R1: While the power-on reset input `porN` is low, `sysRst` is at its asserted level, and it stays asserted after `porN` rises until the recovery timeout of R6 has elapsed.
- R2: With `rstActiveHigh` = 1 the asserted level of `sysRst` is 1. With `rstActiveHigh` = 0 the asserted level is 0. In both cases the deasserted level is the opposite value.
- R3: While reset is released, a run of fewer than `GLITCH_CYCLES` consecutive clocks with `belowThr` = 1 leaves `sysRst` deasserted.
- R4: While reset is released, a run of at least `GLITCH_CYCLES` consecutive clocks with `belowThr` = 1 asserts `sysRst`. The output changes after exactly `GLITCH_CYCLES`+3 rising edges, counted from the first edge that samples the flag high.
- R5: `sysRst` stays asserted for as long as `belowThr` stays 1, whatever the duration.
- R6: After `belowThr` returns to 0, `sysRst` is still asserted after `TIMEOUT_CYCLES`+3 rising edges and is deasserted after `TIMEOUT_CYCLES`+4 rising edges.
- R7: A qualifying undervoltage (R4) during the recovery timeout reasserts hold. The full timeout of R6 then restarts from the end of that dip.
- R8: A sub-threshold dip (R3) during the recovery timeout does not change the moment of release.
- R9: The run count clears on any clock with the flag low. Two short runs separated by one low clock do not qualify, even when their combined length reaches `GLITCH_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| belowThr | input | 1 | Comparator flag: 1 when the supply is under threshold |
| rstActiveHigh | input | 1 | Polarity strap: 1 selects active-high reset output |
| sysRst | output | 1 | System reset output, push-pull |

## Verification
The bench builds the block with `GLITCH_CYCLES` = 4 and `TIMEOUT_CYCLES` = 20. With these values the filter boundary (3 versus 4 clocks) can be checked exactly, and so can the release edge at 23 versus 24 clocks after recovery. A hold can also be restarted several times inside one short run. These small values also make it practical to sample every cycle of a filtered dip and of a split dip. Both strap settings are exercised.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_RUN     = 2'd2
  } seqState_t;

  typedef struct packed {
    logic tmrClear;
    logic tmrRun;
  } seqStrobe_t;

endpackage

// File: rtl/supply_reset_dp.sv
module supply_reset_dp
  import supply_reset_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int GLITCH_CYCLES  = 100,
  parameter int TIMEOUT_CYCLES = 12_000_000
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       belowThr,
  input  seqStrobe_t strobe,
  output logic       underVolt,
  output logic       tmrDone
);

  localparam int GCW = $clog2(GLITCH_CYCLES + 1);
  localparam int TCW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [GCW-1:0] G_MAX  = GCW'(GLITCH_CYCLES);
  localparam logic [TCW-1:0] T_LAST = TCW'(TIMEOUT_CYCLES - 1);

  // Comparator flag synchronizer; presets to "below" so power-up reads as undervoltage
  logic [SYNC_STAGES-1:0] syncQ;
  logic flagSync;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], belowThr};
  end
  assign flagSync = syncQ[SYNC_STAGES-1];

  // Consecutive-clock run counter, saturating at the qualification length
  logic [GCW-1:0] gCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              gCnt <= G_MAX;
    else if (!flagSync)     gCnt <= '0;
    else if (gCnt != G_MAX) gCnt <= gCnt + 1'b1;
  end
  assign underVolt = (gCnt == G_MAX);

  // Recovery timer, driven by control strobes
  logic [TCW-1:0] tmrCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                           tmrCnt <= '0;
    else if (strobe.tmrClear)            tmrCnt <= '0;
    else if (strobe.tmrRun && !tmrDone)  tmrCnt <= tmrCnt + 1'b1;
  end
  assign tmrDone = (tmrCnt == T_LAST);

  // R3/R9: qualification only after a full unbroken run
  a_r3_qual_needs_run: assert property (@(posedge clk) disable iff (!porN)
    $rose(underVolt) |-> ($past(flagSync) && ($past(gCnt) == G_MAX - 1'b1)));

  // R9: a low flag breaks any pending qualification
  a_r9_low_clears_run: assert property (@(posedge clk) disable iff (!porN)
    !flagSync |=> !underVolt);

  // R6: timer never runs past its terminal value
  a_r6_timer_bound: assert property (@(posedge clk) disable iff (!porN)
    tmrCnt <= T_LAST);

endmodule

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl
  import supply_reset_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       underVolt,
  input  logic       tmrDone,
  output seqStrobe_t strobe,
  output logic       rstActive
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_HOLD:    if (!underVolt) stateNxt = ST_TIMEOUT;
      ST_TIMEOUT: if (underVolt)  stateNxt = ST_HOLD;
                  else if (tmrDone) stateNxt = ST_RUN;
      ST_RUN:     if (underVolt)  stateNxt = ST_HOLD;
      default:    stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_HOLD;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.tmrClear = (state == ST_HOLD);
    strobe.tmrRun   = (state == ST_TIMEOUT);
  end

  assign rstActive = (state != ST_RUN);

  // R4/R5: a qualified undervoltage always lands in hold
  a_r4_undervolt_holds: assert property (@(posedge clk) disable iff (!porN)
    underVolt |=> (state == ST_HOLD));

  // R7: qualified dip during the timeout abandons the countdown
  a_r7_timeout_restart: assert property (@(posedge clk) disable iff (!porN)
    ((state == ST_TIMEOUT) && underVolt) |=> strobe.tmrClear);

  // R6: release only follows a completed timer
  a_r6_release_after_done: assert property (@(posedge clk) disable iff (!porN)
    $fell(rstActive) |-> ($past(tmrDone) && !$past(underVolt)));

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import supply_reset_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int TIMEOUT_MS     = 240,
  parameter int SYNC_STAGES    = 2,
  parameter int GLITCH_CYCLES  = 100,
  parameter int TIMEOUT_CYCLES = (CLK_HZ / 1000) * TIMEOUT_MS
) (
  input  logic clk,
  input  logic porN,
  input  logic belowThr,
  input  logic rstActiveHigh,
  output logic sysRst
);

  seqStrobe_t strobe;
  logic underVolt;
  logic tmrDone;
  logic rstActive;

  supply_reset_dp #(
    .SYNC_STAGES   (SYNC_STAGES),
    .GLITCH_CYCLES (GLITCH_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) uDp (
    .clk      (clk),
    .porN     (porN),
    .belowThr (belowThr),
    .strobe   (strobe),
    .underVolt(underVolt),
    .tmrDone  (tmrDone)
  );

  supply_reset_ctrl uCtrl (
    .clk      (clk),
    .porN     (porN),
    .underVolt(underVolt),
    .tmrDone  (tmrDone),
    .strobe   (strobe),
    .rstActive(rstActive)
  );

  assign sysRst = rstActiveHigh ? rstActive : ~rstActive;

  // R1: reset is asserted while power-on reset is applied
  a_r1_por_asserted: assert property (@(posedge clk)
    !porN |-> (sysRst == rstActiveHigh));

endmodule

// File: tb/tb_supply_reset_seq.sv
`timescale 1ns/1ps
module tb_supply_reset_seq;

  localparam int G = 4;
  localparam int T = 20;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic belowThr = 1'b0;
  logic rstActiveHigh = 1'b1;
  logic sysRst;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  supply_reset_seq #(
    .SYNC_STAGES   (2),
    .GLITCH_CYCLES (G),
    .TIMEOUT_CYCLES(T)
  ) dut (
    .clk          (clk),
    .porN         (porN),
    .belowThr     (belowThr),
    .rstActiveHigh(rstActiveHigh),
    .sysRst       (sysRst)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectRst(input bit asserted, input string req);
    logic expLvl;
    expLvl = asserted ? rstActiveHigh : ~rstActiveHigh;
    nChecks++;
    if (sysRst !== expLvl) begin
      nFails++;
      $display("FAIL %s: sysRst=%b expected %b at %0t", req, sysRst, expLvl, $time);
    end
  endtask

  task automatic powerOn(input bit pol);
    porN = 1'b0; belowThr = 1'b0; rstActiveHigh = pol;
    tick(3);
    expectRst(1, "R1 during por");
    expectRst(1, "R2 asserted level");
    porN = 1'b1;
    tick(T + 3);
    expectRst(1, "R1 held until timeout");
    tick(1);
    expectRst(0, "R6 release after por");
    expectRst(0, "R2 deasserted level");
  endtask

  task automatic shortDip();
    belowThr = 1'b1; tick(G - 1); belowThr = 1'b0;
    for (int i = 0; i < G + 6; i++) begin
      tick(1);
      expectRst(0, "R3 short dip ignored");
    end
  endtask

  task automatic splitDip();
    belowThr = 1'b1; tick(G - 1);
    belowThr = 1'b0; tick(1);
    belowThr = 1'b1; tick(G - 1);
    belowThr = 1'b0;
    for (int i = 0; i < G + 6; i++) begin
      tick(1);
      expectRst(0, "R9 split dip ignored");
    end
  endtask

  task automatic longDip();
    belowThr = 1'b1;
    tick(G + 2);
    expectRst(0, "R4 not yet asserted");
    tick(1);
    expectRst(1, "R4 asserted on qualified dip");
    for (int i = 0; i < 40; i++) begin
      tick(1);
      expectRst(1, "R5 held while below");
    end
    belowThr = 1'b0;
    tick(T + 3);
    expectRst(1, "R6 still asserted");
    tick(1);
    expectRst(0, "R6 released");
  endtask

  task automatic enterTimeout();
    belowThr = 1'b1; tick(G + 8);
    expectRst(1, "R4 entry dip");
    belowThr = 1'b0;
  endtask

  task automatic restartTimeout();
    enterTimeout();
    tick(10);
    expectRst(1, "R6 within timeout");
    belowThr = 1'b1; tick(G); belowThr = 1'b0;
    tick(T + 3);
    expectRst(1, "R7 timeout restarted");
    tick(1);
    expectRst(0, "R7 release after restart");
  endtask

  task automatic shortDipInTimeout();
    enterTimeout();
    tick(5);
    belowThr = 1'b1; tick(G - 1); belowThr = 1'b0;
    tick(T + 3 - 5 - (G - 1));
    expectRst(1, "R8 still asserted");
    tick(1);
    expectRst(0, "R8 release unchanged");
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    powerOn(1'b1);
    shortDip();
    splitDip();
    longDip();
    restartTimeout();
    shortDipInTimeout();
    powerOn(1'b0);
    shortDip();
    longDip();
    restartTimeout();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule